// File: doc/BRIEF.md
# Safeload Parameter Transfer Controller

This block keeps a handful of pending parameter updates in staging slots. It moves them into the parameter RAM at a point in the audio frame where the processing core is not reading them. A host fills any of the slots, each with a RAM address and a data word, and then raises a transfer request. The block waits for the next frame-boundary strobe. It then writes the valid slots into the RAM one per clock, lowest slot first, and raises a completion flag in its status word. Reading the status word clears that flag.

The block also handles a core shutdown. While a shutdown is requested, the next frame boundary at which no copy is running puts the block into a halted state. A second status flag shows this state. While halted, the host owns the RAM write port directly and can touch any location without audible artefacts. One frame boundary after the request is withdrawn, normal operation resumes. A transfer requested during the halt is held until then.

Top module: `safeload_ctrl`

## Requirements
- R1: A staging write to slot index 0..4 stores that address and data word and marks the slot valid, overwriting any earlier contents. A staging write to index 5 or higher is ignored.
- R2: After a transfer request, the RAM write port stays idle until the first frame-boundary strobe. The copy starts on the clock after that strobe.
- R3: A copy drives one RAM write per clock for each valid slot, in ascending slot index, with that slot's address and data. Each slot's valid mark clears as it is copied, so a copied slot is never written twice.
- R4: Status bit 0 (completion) rises on the clock after the last copy write. If no slot is valid when the copy would start, it rises on the clock after that frame boundary and no RAM write occurs.
- R5: A status read returns the current flags. Bit 0 clears on the clock after a read strobe, unless a completion is being set in that same clock.
- R6: A transfer request and any staging write that arrive while a copy is running are ignored.
- R7: Status bit 1 (halted) rises at the first frame boundary with the shutdown request high and no copy running or starting. It falls at the first frame boundary with the request low.
- R8: While halted, the host write enable, address and data drive the RAM port directly. While not halted and not copying, host writes never reach the RAM.
- R9: No copy starts while halted, including at the boundary that ends the halt. A pending request is served at the first later boundary.
- R10: After reset, both status bits are 0, no slot is valid and the RAM write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_we | input | 1 | Staging slot write strobe |
| stg_slot | input | SLOT_W (3) | Staging slot index |
| stg_addr | input | ADDR_W (10) | RAM address for the slot |
| stg_data | input | DATA_W (28) | Data word for the slot |
| xfer_req | input | 1 | Transfer request strobe |
| frame_tick | input | 1 | Frame-boundary strobe |
| halt_req | input | 1 | Core shutdown request (level) |
| host_we | input | 1 | Direct host RAM write enable, honoured while halted |
| host_addr | input | ADDR_W (10) | Direct host RAM address |
| host_wdata | input | DATA_W (28) | Direct host RAM write data |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | ADDR_W (10) | Parameter RAM address |
| ram_wdata | output | DATA_W (28) | Parameter RAM write data |
| stat_rd | input | 1 | Status read strobe |
| stat_data | output | 2 | Status word: bit 1 halted, bit 0 copy complete |

## Verification
The assertions assume that frame_tick and xfer_req are single-cycle strobes, that halt_req changes only between boundaries, and that host_we is used only while bit 1 of the status word is set. The bench keeps to these assumptions. It drives every strobe for exactly one clock on the falling edge. It raises host writes only inside the halted window, except for one deliberate write outside that window, which checks that the write is blocked. Random staging patterns pick slot indices from 0 to 6, so out-of-range writes, overwrites and empty transfers all occur.

// File: rtl/safeload_pkg.sv
// Shared types for the safeload transfer controller.
package safeload_pkg;
    // Copy sequencer states.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_COPY = 1'b1
    } seq_state_t;
endpackage

// File: rtl/sl_stage_bank.sv
// Staging slot bank: holds an address/data pair and a valid mark per slot,
// and presents the lowest-index valid slot for copying.
// Assumes wr_en and clr_en are never high in the same cycle (top gates writes
// while copying) and that wr_slot is already range-checked by the caller.
module sl_stage_bank #(
    parameter int NUM_SLOTS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    output logic              any_valid,
    output logic              last_one,
    output logic [ADDR_W-1:0] pick_addr,
    output logic [DATA_W-1:0] pick_data
);
    logic [NUM_SLOTS-1:0] valid_q;
    logic [ADDR_W-1:0]    addr_q [NUM_SLOTS];
    logic [DATA_W-1:0]    data_q [NUM_SLOTS];
    logic [SLOT_W-1:0]    pick_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Load a slot on write; drop its valid mark when it is copied.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                data_q[g]  <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(g)) begin
                valid_q[g] <= 1'b1;
                addr_q[g]  <= wr_addr;
                data_q[g]  <= wr_data;
            end else if (clr_en && pick_idx == SLOT_W'(g)) begin
                valid_q[g] <= 1'b0;
            end
        end
    end

    // Priority pick of the lowest valid slot.
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (valid_q[i]) pick_idx = SLOT_W'(i);
        end
    end

    // Summary flags and the selected slot contents.
    always_comb begin
        any_valid = |valid_q;
        last_one  = any_valid && ((valid_q & (valid_q - 1'b1)) == '0);
        pick_addr = addr_q[pick_idx];
        pick_data = data_q[pick_idx];
    end

    // R3
    clr_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> any_valid);
    // R3
    clr_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> ($countones(valid_q) == $countones($past(valid_q)) - 1));
endmodule

// File: rtl/sl_seq.sv
// Copy and shutdown sequencer: latches transfer requests, starts a copy at a
// frame boundary, tracks completion and halted flags.
// Assumes frame_tick and xfer_req are one-cycle strobes.
module sl_seq
    import safeload_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req,
    input  logic frame_tick,
    input  logic halt_req,
    input  logic stat_rd,
    input  logic any_valid,
    input  logic last_one,
    output logic copying,
    output logic done,
    output logic halted
);
    seq_state_t state_q;
    logic pending_q, done_q, halted_q;
    logic start, finish_copy, done_set, halt_set, halt_clr;

    // Event decode for the current cycle.
    always_comb begin
        start       = frame_tick && pending_q && !halted_q && state_q == SEQ_IDLE;
        finish_copy = state_q == SEQ_COPY && last_one;
        done_set    = (start && !any_valid) || finish_copy;
        halt_set    = frame_tick && halt_req && !halted_q && state_q == SEQ_IDLE && !start;
        halt_clr    = frame_tick && !halt_req && halted_q;
    end

    // Pending request latch; requests during a copy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pending_q <= 1'b0;
        else if (start)                          pending_q <= 1'b0;
        else if (xfer_req && state_q == SEQ_IDLE) pending_q <= 1'b1;
    end

    // Copy state: run while valid slots remain.
    always_ff @(posedge clk) begin
        if (!rst_n)                     state_q <= SEQ_IDLE;
        else if (start && any_valid)    state_q <= SEQ_COPY;
        else if (finish_copy)           state_q <= SEQ_IDLE;
    end

    // Completion flag: set wins over clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (done_set) done_q <= 1'b1;
        else if (stat_rd)  done_q <= 1'b0;
    end

    // Halted flag changes only at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)        halted_q <= 1'b0;
        else if (halt_set) halted_q <= 1'b1;
        else if (halt_clr) halted_q <= 1'b0;
    end

    assign copying = state_q == SEQ_COPY;
    assign done    = done_q;
    assign halted  = halted_q;

    // R7
    halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_q) |-> $past(frame_tick && halt_req));
    // R7
    halt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted_q) |-> $past(frame_tick && !halt_req));
    // R9
    no_copy_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == SEQ_COPY && halted_q));
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && stat_rd && !done_set) |=> !done_q);
    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(state_q == SEQ_COPY || frame_tick));
endmodule

// File: rtl/safeload_ctrl.sv
// Safeload parameter transfer controller top: staging bank, sequencer and
// the RAM port mux that hands the port to the host while halted.
// Assumes host_we is only meaningful while the halted flag is set.
module safeload_ctrl #(
    parameter int NUM_SLOTS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_we,
    input  logic [SLOT_W-1:0] stg_slot,
    input  logic [ADDR_W-1:0] stg_addr,
    input  logic [DATA_W-1:0] stg_data,
    input  logic              xfer_req,
    input  logic              frame_tick,
    input  logic              halt_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic              stat_rd,
    output logic [1:0]        stat_data
);
    logic copying, done, halted, any_valid, last_one, bank_wr;
    logic [ADDR_W-1:0] pick_addr;
    logic [DATA_W-1:0] pick_data;

    // Accept staging writes only for existing slots and outside a copy.
    assign bank_wr = stg_we && !copying &&
                     ({1'b0, stg_slot} < (SLOT_W + 1)'(NUM_SLOTS));

    sl_stage_bank #(
        .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bank_wr), .wr_slot(stg_slot), .wr_addr(stg_addr), .wr_data(stg_data),
        .clr_en(copying),
        .any_valid(any_valid), .last_one(last_one),
        .pick_addr(pick_addr), .pick_data(pick_data)
    );

    sl_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .xfer_req(xfer_req), .frame_tick(frame_tick), .halt_req(halt_req),
        .stat_rd(stat_rd), .any_valid(any_valid), .last_one(last_one),
        .copying(copying), .done(done), .halted(halted)
    );

    // RAM port owner: host while halted, copy engine otherwise.
    always_comb begin
        if (halted) begin
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end else begin
            ram_we    = copying;
            ram_addr  = pick_addr;
            ram_wdata = pick_data;
        end
    end

    assign stat_data = {halted, done};

    // R8
    idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_data[1] && !copying) |-> !ram_we);
    // R2
    copy_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copying) |-> $past(frame_tick));
endmodule

// File: tb/safeload_ctrl_tb_top.sv
module safeload_ctrl_tb_top;
    localparam int NS = 5, AW = 10, DW = 28, SW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, stg_we, xfer_req, frame_tick, halt_req, host_we, stat_rd;
    logic [SW-1:0] stg_slot;
    logic [AW-1:0] stg_addr, host_addr, ram_addr;
    logic [DW-1:0] stg_data, host_wdata, ram_wdata;
    logic ram_we;
    logic [1:0] stat_data;

    safeload_ctrl #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .stg_we(stg_we), .stg_slot(stg_slot), .stg_addr(stg_addr), .stg_data(stg_data),
        .xfer_req(xfer_req), .frame_tick(frame_tick), .halt_req(halt_req),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .stat_rd(stat_rd), .stat_data(stat_data)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    bit          m_valid [NS];
    logic [AW-1:0] m_addr [NS];
    logic [DW-1:0] m_data [NS];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int next_slot();
        for (int i = 0; i < NS; i++) if (m_valid[i]) return i;
        return -1;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // R1: staging write; model ignores out-of-range slots
    task automatic stage(int slot, logic [AW-1:0] a, logic [DW-1:0] d);
        stg_we = 1; stg_slot = SW'(slot); stg_addr = a; stg_data = d;
        step();
        stg_we = 0;
        if (slot < NS) begin
            m_valid[slot] = 1; m_addr[slot] = a; m_data[slot] = d;
        end
    endtask

    task automatic run_copy(bit poke);
        bit first = 1;
        xfer_req = 1; step(); xfer_req = 0;
        for (int k = 0; k < 2; k++) begin
            chk("R2", "ram_we before boundary", ram_we, 0);
            step();
        end
        frame_tick = 1; step(); frame_tick = 0;
        if (next_slot() < 0) begin
            chk("R4", "empty copy done", stat_data[0], 1);
            chk("R4", "empty copy ram_we", ram_we, 0);
        end else begin
            while (next_slot() >= 0) begin
                int s = next_slot();
                chk("R3", "ram_we", ram_we, 1);
                chk("R3", "ram_addr", ram_addr, m_addr[s]);
                chk("R3", "ram_wdata", ram_wdata, m_data[s]);
                chk("R4", "done low mid copy", stat_data[0], 0);
                if (poke && first) begin
                    xfer_req = 1; stg_we = 1; stg_slot = 0;
                    stg_addr = AW'($urandom); stg_data = DW'($urandom);
                end
                first = 0;
                m_valid[s] = 0;
                step();
                xfer_req = 0; stg_we = 0;
            end
            chk("R3", "ram_we after copy", ram_we, 0);
            chk("R4", "done after copy", stat_data[0], 1);
        end
    endtask

    task automatic read_status(bit exp0);
        stat_rd = 1;
        chk("R5", "read value bit0", stat_data[0], exp0);
        step(); stat_rd = 0;
        chk("R5", "bit0 after read", stat_data[0], 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5A1E));
        rst_n = 0; stg_we = 0; xfer_req = 0; frame_tick = 0; halt_req = 0;
        host_we = 0; stat_rd = 0; stg_slot = 0; stg_addr = 0; stg_data = 0;
        host_addr = 0; host_wdata = 0;
        for (int i = 0; i < NS; i++) begin m_valid[i] = 0; m_addr[i] = 0; m_data[i] = 0; end
        repeat (3) step();
        rst_n = 1; step();
        // R10 reset state
        chk("R10", "stat after reset", stat_data, 0);
        chk("R10", "ram_we after reset", ram_we, 0);
        // R4 empty transfer right after reset
        run_copy(0);
        read_status(1);

        // R1 directed: out-of-range slot ignored, overwrite keeps the last value
        stage(6, 10'h3FF, 28'hBADBAD);
        stage(3, 10'h011, 28'h1);
        stage(3, 10'h022, 28'h2);
        stage(1, 10'h033, 28'h3);
        run_copy(0);
        read_status(1);

        // Random mix, with pokes during copy (R6)
        for (int it = 0; it < 30; it++) begin
            int n = $urandom_range(0, 7);
            bit poke = (it % 3) == 0;
            for (int w = 0; w < n; w++)
                stage($urandom_range(0, 6), AW'($urandom), DW'($urandom));
            run_copy(poke);
            read_status(1);
            if (poke) begin
                // R6: the request in the copy was dropped, so this boundary does nothing
                frame_tick = 1; step(); frame_tick = 0;
                chk("R6", "no write after dropped request", ram_we, 0);
                chk("R6", "no done after dropped request", stat_data[0], 0);
                // R6: slot 0 written during copy must not be valid
                run_copy(0);
                read_status(1);
            end
        end

        // R7/R8/R9 shutdown sequence
        halt_req = 1; step();
        chk("R7", "halted before boundary", stat_data[1], 0);
        frame_tick = 1; step(); frame_tick = 0;
        chk("R7", "halted at boundary", stat_data[1], 1);
        host_we = 1; host_addr = 10'h155; host_wdata = 28'hABCDEF1; #1;
        chk("R8", "host ram_we", ram_we, 1);
        chk("R8", "host ram_addr", ram_addr, 10'h155);
        chk("R8", "host ram_wdata", ram_wdata, 28'hABCDEF1);
        step(); host_we = 0;
        stage(2, 10'h0AA, 28'h00F00D);
        xfer_req = 1; step(); xfer_req = 0;
        frame_tick = 1; step(); frame_tick = 0;
        chk("R9", "no copy while halted", ram_we, 0);
        halt_req = 0; step();
        chk("R7", "still halted before boundary", stat_data[1], 1);
        frame_tick = 1; step(); frame_tick = 0;
        chk("R7", "release at boundary", stat_data[1], 0);
        chk("R9", "no copy at release boundary", ram_we, 0);
        step();
        frame_tick = 1; step(); frame_tick = 0;
        chk("R9", "deferred copy ram_we", ram_we, 1);
        chk("R9", "deferred copy addr", ram_addr, 10'h0AA);
        m_valid[2] = 0;
        step();
        chk("R4", "done after deferred copy", stat_data[0], 1);
        read_status(1);
        host_we = 1; #1;
        chk("R8", "host blocked when not halted", ram_we, 0);
        step(); host_we = 0;

        summary();
    end
endmodule